// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Two-Entry Receive Queue

This block recovers words from a single asynchronous serial line. An external rate generator supplies a one-cycle tick at sixteen times the bit rate. The receiver uses that tick to find a start bit and sample each data bit near its centre. It also checks the stop level. Each finished word is written into a two-entry queue. A word holds 8 data bits, or 9 when the nine-bit mode input is high. Its framing-error bit and its ninth bit travel with it through the queue.

The consumer watches `rx_avail` and reads the head entry from `rx_data`, `rx_bit9` and `rx_ferr`. A one-cycle `pop` advances to the next entry. If a word completes while both entries are occupied and no pop is taking place, the word is dropped and `rx_overrun` sets. The flag stays set, and the receiver accepts no further words until `rx_en` is lowered and raised again. Lowering `rx_en` does not flush the queue, so words already queued can still be read.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, `rx_avail` and `rx_overrun` are 0.
- R2: While `rx_en` is low, the receiver is held idle, and activity on `rx_in` adds no entry to the queue.
- R3: A falling edge on the line starts a frame. The frame is abandoned, and no word results, if the line is high at the 8th tick after that edge.
- R4: Each data bit and the stop bit take the majority of the line samples at ticks 7, 8 and 9 of the bit. A low pulse that covers only one of those samples does not alter the received bit.
- R5: Data bits arrive least significant bit first, and the head word's low 8 bits appear on `rx_data`.
- R6: When `nine_bit` is 1 at the start of a frame, a ninth data bit is received and presented on `rx_bit9`. In 8-bit mode, `rx_bit9` reads 0.
- R7: `rx_ferr` is 1 for an entry whose sampled stop bit was 0, and 0 otherwise. It is stored per entry and moves with its word.
- R8: The queue holds two words in arrival order. `rx_avail` is 1 whenever at least one word is queued. `pop` removes the head, and the outputs then show the next entry.
- R9: If a word completes while both entries are full and no pop occurs in that cycle, the word is discarded and `rx_overrun` sets. It remains set while `rx_en` stays high.
- R10: While `rx_overrun` is 1, no new word enters the queue. Queued entries can still be popped.
- R11: Setting `rx_en` low clears `rx_overrun`. After `rx_en` returns high, reception resumes.
- R12: A `pop` while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; a low level clears the overrun flag and idles the receiver |
| nine_bit | input | 1 | Selects 9 data bits per frame when high |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| pop | input | 1 | Removes the head entry of the queue |
| rx_avail | output | 1 | At least one word is queued |
| rx_data | output | DATA_W | Low data bits of the head entry |
| rx_bit9 | output | 1 | Ninth data bit of the head entry |
| rx_ferr | output | 1 | Framing error of the head entry |
| rx_overrun | output | 1 | Sticky overrun flag |

## Verification
The properties assume that `pop` is a single-cycle request and that `rx_en` is either steady or toggled between frames. They also assume `tick16` is a regular strobe that is never held high for consecutive cycles.

The bench produces the tick from its own divider, once every two clocks. It lays out every bit as exactly 16 ticks and raises `pop` for one cycle at a time. It changes `rx_en` only while the line is idle. The single glitch it injects is two clocks wide, so it covers exactly one of the three centre samples.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

endpackage

// File: rtl/urx_sync.sv
// Multi-stage synchronizer for the serial line with falling-edge detect.
module urx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic fall
);

  logic [STAGES-1:0] sr;
  logic              last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b1;
    else     last <= sr[STAGES-1];
  end

  assign dout = sr[STAGES-1];
  assign fall = last & ~sr[STAGES-1];

endmodule

// File: rtl/urx_framer.sv
// Oversampling frame recovery: start confirm, centre majority vote, stop check.
module urx_framer
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            nine,
  input  logic            tick,
  input  logic            rxd,
  input  logic            fall,
  output logic            done,
  output logic [DATA_W:0] word,
  output logic            ferr
);

  localparam int CNT_W = $clog2(OSR);
  localparam int TN_W  = CNT_W + 1;
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam int T_A   = OSR / 2 - 1;
  localparam int T_B   = OSR / 2;
  localparam int T_C   = OSR / 2 + 1;

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [TN_W-1:0]   tnum;
  logic [BIT_W-1:0]  bidx;
  logic [BIT_W-1:0]  last_idx;
  logic [DATA_W:0]   shreg;
  logic              s_a, s_b, vote, nine_q;

  assign tnum     = {1'b0, cnt} + 1'b1;
  assign vote     = (s_a & s_b) | (s_a & rxd) | (s_b & rxd);
  assign last_idx = nine_q ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      done   <= 1'b0;
      s_a    <= 1'b1;
      s_b    <= 1'b1;
      nine_q <= 1'b0;
      shreg  <= '0;
      word   <= '0;
      ferr   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state != ST_IDLE && tick) begin
        if (tnum == TN_W'(OSR)) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
        if (tnum == TN_W'(T_A)) s_a <= rxd;
        if (tnum == TN_W'(T_B)) s_b <= rxd;
      end
      unique case (state)
        ST_IDLE: begin
          if (fall) begin
            state  <= ST_START;
            cnt    <= '0;
            nine_q <= nine;
            shreg  <= '0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (tnum == TN_W'(T_B) && rxd) begin
              state <= ST_IDLE;
            end else if (tnum == TN_W'(OSR)) begin
              state <= ST_DATA;
              bidx  <= '0;
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (tnum == TN_W'(T_C)) shreg[bidx] <= vote;
            if (tnum == TN_W'(OSR)) begin
              if (bidx == last_idx) state <= ST_STOP;
              else                  bidx  <= bidx + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick && tnum == TN_W'(T_C)) begin
            done  <= 1'b1;
            ferr  <= ~vote;
            word  <= nine_q ? shreg : {1'b0, shreg[DATA_W-1:0]};
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/urx_fifo.sv
// Small synchronous queue; storage has no reset so it can map to RAM.
module urx_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             not_empty,
  output logic             full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_wr, do_rd;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CNT_W'(DEPTH));
  assign not_empty = (count != '0);
  assign do_rd     = pop & not_empty;
  assign do_wr     = push & (~full | do_rd);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= nxt(wr_ptr);
      if (do_rd) rd_ptr <= nxt(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rd_ptr];

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              nine_bit,
  input  logic              tick16,
  input  logic              rx_in,
  input  logic              pop,
  output logic              rx_avail,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_ferr,
  output logic              rx_overrun
);

  localparam int ENT_W = DATA_W + 2;

  logic            rxd, fall, done, ferr, full, push, ovr_q;
  logic [DATA_W:0] word;
  logic [ENT_W-1:0] head;

  urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_in),
    .dout (rxd),
    .fall (fall)
  );

  urx_framer #(.DATA_W(DATA_W), .OSR(OSR)) u_framer (
    .clk    (clk),
    .rst    (rst),
    .enable (rx_en & ~ovr_q),
    .nine   (nine_bit),
    .tick   (tick16),
    .rxd    (rxd),
    .fall   (fall),
    .done   (done),
    .word   (word),
    .ferr   (ferr)
  );

  assign push = done & rx_en & ~ovr_q;

  always_ff @(posedge clk) begin
    if (rst || !rx_en)             ovr_q <= 1'b0;
    else if (push && full && !pop) ovr_q <= 1'b1;
  end

  urx_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .wdata     ({ferr, word}),
    .pop       (pop),
    .head      (head),
    .not_empty (rx_avail),
    .full      (full)
  );

  assign rx_data    = head[DATA_W-1:0];
  assign rx_bit9    = head[DATA_W];
  assign rx_ferr    = head[DATA_W+1];
  assign rx_overrun = ovr_q;

endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_en,
  input logic              pop,
  input logic              rx_avail,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_bit9,
  input logic              rx_ferr,
  input logic              rx_overrun
);

  a_r2_disabled_no_entry: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !rx_avail) |=> !rx_avail);

  a_r8_head_held: assert property (@(posedge clk) disable iff (rst)
    (rx_avail && !pop) |=> (rx_avail && $stable({rx_data, rx_bit9, rx_ferr})));

  a_r9_overrun_needs_data: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_overrun) |-> rx_avail);

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && rx_en) |=> rx_overrun);

  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && !rx_avail) |=> !rx_avail);

  a_r11_clear_on_disable: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !rx_overrun);

endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rx_en      (rx_en),
  .pop        (pop),
  .rx_avail   (rx_avail),
  .rx_data    (rx_data),
  .rx_bit9    (rx_bit9),
  .rx_ferr    (rx_ferr),
  .rx_overrun (rx_overrun)
);

// File: tb/uart_rx_fifo_tb.sv
`timescale 1ns/1ps
module uart_rx_fifo_tb;

  localparam int BITCLK = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0, nine_bit = 1'b0, tick16 = 1'b0, rx_in = 1'b1, pop = 1'b0;
  logic       rx_avail, rx_bit9, rx_ferr, rx_overrun;
  logic [7:0] rx_data;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  always @(posedge clk) tick16 <= rst ? 1'b0 : ~tick16;

  uart_rx_fifo u_dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .nine_bit(nine_bit),
    .tick16(tick16), .rx_in(rx_in), .pop(pop),
    .rx_avail(rx_avail), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .rx_ferr(rx_ferr), .rx_overrun(rx_overrun)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic hold_bit(input logic v, input bit glitch);
    for (int c = 0; c < BITCLK; c++) begin
      rx_in = (glitch && (c == 16 || c == 17)) ? ~v : v;
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [8:0] w, input bit nine, input logic stop_v, input int gbit);
    int nb;
    nb = nine ? 9 : 8;
    hold_bit(1'b0, 1'b0);
    for (int i = 0; i < nb; i++) hold_bit(w[i], gbit == i);
    hold_bit(stop_v, 1'b0);
    rx_in = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic do_pop();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic head_is(input string tag, input int d, input int b9, input int fe);
    chk_eq({tag, " avail"}, int'(rx_avail), 1);
    chk_eq({tag, " data"}, int'(rx_data), d);
    chk_eq({tag, " bit9"}, int'(rx_bit9), b9);
    chk_eq({tag, " ferr"}, int'(rx_ferr), fe);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R1 avail after reset", int'(rx_avail), 0);
    chk_eq("R1 overrun after reset", int'(rx_overrun), 0);
    rx_en = 1'b1;
    repeat (8) @(negedge clk);

    // R5 sweep of all byte values in 8-bit mode (R6 bit9 reads 0)
    for (int v = 0; v < 256; v++) begin
      send(9'(v), 1'b0, 1'b1, -1);
      head_is("R5 sweep", v, 0, 0);
      do_pop();
      chk_eq("R8 empty after pop", int'(rx_avail), 0);
    end

    // R6 nine-bit mode
    nine_bit = 1'b1;
    send(9'h1A5, 1'b1, 1'b1, -1);
    head_is("R6 ninth=1", 'hA5, 1, 0);
    do_pop();
    send(9'h0F0, 1'b1, 1'b1, -1);
    head_is("R6 ninth=0", 'hF0, 0, 0);
    do_pop();
    nine_bit = 1'b0;

    // R4 one-sample glitch in bits 0 and 5
    send(9'h021, 1'b0, 1'b1, 0);
    head_is("R4 glitch bit0", 'h21, 0, 0);
    do_pop();
    send(9'h0DE, 1'b0, 1'b1, 5);
    head_is("R4 glitch bit5", 'hDE, 0, 0);
    do_pop();

    // R7 and R8 per-entry status in order
    send(9'h03C, 1'b0, 1'b0, -1);
    send(9'h0C3, 1'b0, 1'b1, -1);
    head_is("R7 first entry ferr", 'h3C, 0, 1);
    do_pop();
    head_is("R8 second entry", 'hC3, 0, 0);
    do_pop();
    chk_eq("R8 drained", int'(rx_avail), 0);

    // R9 overrun and R10 frozen queue
    send(9'h011, 1'b0, 1'b1, -1);
    send(9'h022, 1'b0, 1'b0, -1);
    chk_eq("R9 no overrun at two", int'(rx_overrun), 0);
    send(9'h033, 1'b0, 1'b1, -1);
    chk_eq("R9 overrun set", int'(rx_overrun), 1);
    head_is("R9 head kept", 'h11, 0, 0);
    do_pop();
    send(9'h044, 1'b0, 1'b1, -1);
    chk_eq("R9 overrun sticky", int'(rx_overrun), 1);
    head_is("R10 second entry", 'h22, 0, 1);
    do_pop();
    chk_eq("R10 no word accepted", int'(rx_avail), 0);

    // R11 toggle enable clears overrun
    rx_en = 1'b0;
    @(negedge clk);
    chk_eq("R11 overrun cleared", int'(rx_overrun), 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    send(9'h0A7, 1'b0, 1'b1, -1);
    head_is("R11 resumed", 'hA7, 0, 0);
    do_pop();

    // R2 disabled receiver ignores line
    rx_en = 1'b0;
    send(9'h05A, 1'b0, 1'b1, -1);
    chk_eq("R2 no entry while disabled", int'(rx_avail), 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // R3 short low pulse is a false start
    rx_in = 1'b0;
    repeat (8) @(negedge clk);
    rx_in = 1'b1;
    repeat (12 * BITCLK) @(negedge clk);
    chk_eq("R3 false start rejected", int'(rx_avail), 0);

    // R12 pop while empty has no effect
    do_pop();
    do_pop();
    chk_eq("R12 still empty", int'(rx_avail), 0);
    send(9'h096, 1'b0, 1'b1, -1);
    head_is("R12 word after empty pops", 'h96, 0, 0);
    do_pop();
    chk_eq("R12 single pop empties", int'(rx_avail), 0);

    finish_run();
  end

endmodule